// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides when a processor core is clocked, when its direct memory access cycle steals may run, and when its oscillator may stop. It has three reduced-power states. In power-down the core and DMA stop and the oscillator can be switched off. In idle the core waits for an interrupt while DMA keeps running. In slow idle the core keeps running, but only on one cycle in every 16, 32, 64 or 128.

A power-down request arrives as a rising edge on `pd_pin` or on the software bit `sw_pd_force`. The block does not stop the core at once. It first raises a one-cycle nonmaskable interrupt, `pd_irq`, so that handler code can run. The core then confirms entry with `pd_commit`. The core leaves power-down on a new rising edge of `pd_pin`, or when reset is asserted. A rising edge of `pd_pin` therefore means "request power-down" while the core is running or idle, and "wake up" while the core is powered down.

The time from wake-up to resumed execution depends on the oscillator choice latched at entry. If the oscillator was left running, recovery takes a short fixed time. If it was stopped, recovery takes a long settling time. A second option latched at entry tells the core whether to resume with its saved context or to start from a cleared one. The oscillator itself is modelled only as this wait count.

Top module: `lpm_sequencer`

## Requirements
- R1: After reset, the outputs are: `core_en`=1, `core_div_en`=1, `dma_en`=1, `osc_en`=1, `pd_ack`=0, `pd_irq`=0 and `ctx_clear_sel`=1 (start from a cleared context).
- R2: A power-down request is a rising edge of `pd_pin` or of `sw_pd_force`, sampled while running. It raises `pd_irq` for exactly one cycle, starting one cycle after the sampling edge. `core_en` stays 1 during that time.
- R3: A `pd_commit` sampled after the request moves the block to power-down. From the next cycle, `pd_ack`=1 and `core_en`, `core_div_en` and `dma_en` are all 0.
- R4: `xtal_off` is latched when `pd_commit` is sampled. Throughout power-down, `osc_en` is the inverse of the latched value. Changing `xtal_off` during power-down has no effect on `osc_en`.
- R5: A rising edge of `pd_pin` during power-down starts recovery. If the oscillator was left running, `core_en` returns to 1 exactly FAST_WAKE (default 200) cycles after the sampling edge, and `pd_ack` drops.
- R6: If the oscillator was stopped, recovery lasts XTAL_WAKE cycles (default 4096). `osc_en` is 1 throughout recovery.
- R7: `ctx_clear_sel` takes the value of `ctx_clear_req` latched when `pd_commit` is sampled. It holds that value through power-down, recovery and afterwards.
- R8: Asserting reset during power-down ends it immediately and restores the R1 outputs.
- R9: An `idle_cmd` with `idle_slow`=0 enters idle. In idle, `core_en`=0, `core_div_en`=0 and `dma_en`=1. One cycle after `irq_pend` is sampled, `core_en` is 1 again.
- R10: An `idle_cmd` with `idle_slow`=1 enters slow idle. The divisor code `idle_div` is latched; codes 00, 01, 10 and 11 give N = 16, 32, 64 and 128. In slow idle, `core_div_en` pulses on one cycle in every N, the first pulse N-1 cycles after entry. `core_en` is 0 and `dma_en` is 1. `irq_pend` returns the block to running.
- R11: A power-down request has priority over an idle command in the same cycle, so the block goes to power-down entry. A power-down request sampled during idle or slow idle also leaves idle at once and raises `pd_irq`, even when `irq_pend` is 0.
- R12: During power-down, a rising edge of `sw_pd_force` is ignored: `pd_ack` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous reset, active low; also ends power-down |
| pd_pin | input | 1 | Power-down pin; a rising edge requests power-down, or wakes the core when it is powered down |
| sw_pd_force | input | 1 | Software power-down force bit; a rising edge requests power-down |
| pd_commit | input | 1 | Core confirms power-down entry after running its handler |
| xtal_off | input | 1 | 1: stop the oscillator during power-down |
| ctx_clear_req | input | 1 | 1: start from a cleared context after power-down |
| idle_cmd | input | 1 | One-cycle idle command |
| idle_slow | input | 1 | With `idle_cmd`: 1 selects slow idle, 0 selects idle |
| idle_div | input | 2 | Slow-idle divisor code (00..11 give 16..128) |
| irq_pend | input | 1 | A pending unmasked interrupt; wakes the core from idle |
| pd_irq | output | 1 | One-cycle nonmaskable power-down interrupt |
| pd_ack | output | 1 | Power-down acknowledge |
| osc_en | output | 1 | Oscillator enable |
| core_en | output | 1 | Full-rate core clock enable |
| core_div_en | output | 1 | Core clock enable including the slow-idle divided rate |
| dma_en | output | 1 | Permission for DMA cycle steals |
| ctx_clear_sel | output | 1 | 1: start from a cleared context; 0: resume with the saved context |

## Verification
Two functions can meet in one clock: a power-down request, and an idle command or idle wake-up. The bench raises `pd_pin` in the same cycle as `idle_cmd`. It judges the result by `pd_irq` firing and `core_en` staying high, which shows the power-down path was taken and idle was dropped. In a second case it raises `sw_pd_force` while the core is idle and `irq_pend` is low. It expects the block to leave idle for power-down entry in the very next cycle.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    ST_RUN        = 3'd0,
    ST_PD_ENTRY   = 3'd1,
    ST_PD         = 3'd2,
    ST_PD_RECOVER = 3'd3,
    ST_IDLE       = 3'd4,
    ST_SLOW_IDLE  = 3'd5
  } lpm_state_e;

  // Slow-idle period: 2**(base_log + code) input cycles.
  function automatic int unsigned slow_period(input logic [1:0] code,
                                              input int unsigned base_log);
    return 32'd1 << (base_log + int'(code));
  endfunction

  // Recovery length, chosen by the latched oscillator option.
  function automatic int unsigned wake_cycles(input logic osc_off,
                                              input int unsigned fast,
                                              input int unsigned slow);
    return osc_off ? slow : fast;
  endfunction

endpackage

// File: rtl/lpm_edge.sv
module lpm_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic rise
);
  logic d_q;

  // Reset value 1: a level that is already high at reset is not an edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) d_q <= 1'b1;
    else        d_q <= d;
  end

  assign rise = d & ~d_q;

  a_r2_rise_once: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/lpm_wake_timer.sv
module lpm_wake_timer
  import lpm_pkg::*;
#(
  parameter int unsigned FAST_WAKE = 200,
  parameter int unsigned XTAL_WAKE = 4096,
  localparam int unsigned CW = $clog2(XTAL_WAKE + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic osc_off,
  output logic done
);
  logic [CW-1:0] cnt;
  logic          active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (load) begin
      cnt    <= CW'(wake_cycles(osc_off, FAST_WAKE, XTAL_WAKE) - 1);
      active <= 1'b1;
    end else if (active) begin
      if (cnt == '0) active <= 1'b0;
      else           cnt    <= cnt - 1'b1;
    end
  end

  assign done = active && (cnt == '0);

  a_r5_load_starts: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> active);
  a_r6_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load) |=> !active);
endmodule

// File: rtl/lpm_clk_div.sv
module lpm_clk_div
  import lpm_pkg::*;
#(
  parameter int unsigned BASE_LOG = 4,
  localparam int unsigned DW = BASE_LOG + 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] code,
  output logic       tick
);
  logic [DW-1:0] cnt;
  logic [DW-1:0] last;

  assign last = DW'(slow_period(code, BASE_LOG) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (!run)        cnt <= '0;
    else if (cnt == last) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == last);

  a_r10_tick_sparse: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
  import lpm_pkg::*;
#(
  parameter int unsigned FAST_WAKE = 200,
  parameter int unsigned XTAL_WAKE = 4096,
  parameter int unsigned DIV_BASE_LOG = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pd_pin,
  input  logic       sw_pd_force,
  input  logic       pd_commit,
  input  logic       xtal_off,
  input  logic       ctx_clear_req,
  input  logic       idle_cmd,
  input  logic       idle_slow,
  input  logic [1:0] idle_div,
  input  logic       irq_pend,
  output logic       pd_irq,
  output logic       pd_ack,
  output logic       osc_en,
  output logic       core_en,
  output logic       core_div_en,
  output logic       dma_en,
  output logic       ctx_clear_sel
);
  localparam int unsigned NSRC = 2;

  lpm_state_e state, state_nx;
  logic [NSRC-1:0] src_lvl, src_rise;
  logic pin_rise, pd_req, wake_load, wake_done, slow_tick;
  logic osc_off_q, ctx_q, pd_irq_q;
  logic [1:0] div_q;

  assign src_lvl = {sw_pd_force, pd_pin};

  for (genvar i = 0; i < NSRC; i++) begin : g_edge
    lpm_edge u_edge (.clk(clk), .rst_n(rst_n), .d(src_lvl[i]), .rise(src_rise[i]));
  end

  assign pin_rise  = src_rise[0];
  assign pd_req    = |src_rise;
  assign wake_load = (state == ST_PD) && pin_rise;

  lpm_wake_timer #(.FAST_WAKE(FAST_WAKE), .XTAL_WAKE(XTAL_WAKE)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(wake_load), .osc_off(osc_off_q), .done(wake_done));

  lpm_clk_div #(.BASE_LOG(DIV_BASE_LOG)) u_div (
    .clk(clk), .rst_n(rst_n), .run(state == ST_SLOW_IDLE), .code(div_q), .tick(slow_tick));

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_RUN: begin
        if (pd_req)        state_nx = ST_PD_ENTRY;
        else if (idle_cmd) state_nx = idle_slow ? ST_SLOW_IDLE : ST_IDLE;
      end
      ST_PD_ENTRY:   if (pd_commit) state_nx = ST_PD;
      ST_PD:         if (pin_rise)  state_nx = ST_PD_RECOVER;
      ST_PD_RECOVER: if (wake_done) state_nx = ST_RUN;
      ST_IDLE, ST_SLOW_IDLE: begin
        if (pd_req)        state_nx = ST_PD_ENTRY;
        else if (irq_pend) state_nx = ST_RUN;
      end
      default: state_nx = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_RUN;
      osc_off_q <= 1'b0;
      ctx_q     <= 1'b1;
      div_q     <= 2'b00;
      pd_irq_q  <= 1'b0;
    end else begin
      state    <= state_nx;
      pd_irq_q <= (state_nx == ST_PD_ENTRY) && (state != ST_PD_ENTRY);
      if (state == ST_PD_ENTRY && pd_commit) begin
        osc_off_q <= xtal_off;
        ctx_q     <= ctx_clear_req;
      end
      if (state == ST_RUN && idle_cmd) div_q <= idle_div;
    end
  end

  assign pd_irq        = pd_irq_q;
  assign pd_ack        = (state == ST_PD);
  assign osc_en        = !(osc_off_q && state == ST_PD);
  assign core_en       = (state == ST_RUN) || (state == ST_PD_ENTRY);
  assign core_div_en   = core_en || slow_tick;
  assign dma_en        = core_en || (state == ST_IDLE) || (state == ST_SLOW_IDLE);
  assign ctx_clear_sel = ctx_q;

  a_r2_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pd_irq |=> !pd_irq);
  a_r3_commit_acks: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PD_ENTRY && pd_commit) |=> (pd_ack && !dma_en));
  a_r4_osc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_ack && $past(pd_ack)) |-> $stable(osc_en));
  a_r5_exit_holds_core: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_ack && pin_rise) |=> (!core_en && !pd_ack));
  a_r9_idle_wake: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_IDLE || state == ST_SLOW_IDLE) && irq_pend && !pd_req) |=> core_en);
  a_r11_pd_over_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && pd_req) |=> (state == ST_PD_ENTRY && pd_irq));
endmodule

// File: tb/lpm_sequencer_bench.sv
`timescale 1ns/1ps
module lpm_sequencer_bench;
  localparam int FAST = 200;
  localparam int XTAL = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pd_pin = 0, sw_pd_force = 0, pd_commit = 0, xtal_off = 0, ctx_clear_req = 0;
  logic idle_cmd = 0, idle_slow = 0, irq_pend = 0;
  logic [1:0] idle_div = 2'b00;
  logic pd_irq, pd_ack, osc_en, core_en, core_div_en, dma_en, ctx_clear_sel;
  int tests = 0, fails = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  lpm_sequencer u_lpm_sequencer (
    .clk(clk), .rst_n(rst_n), .pd_pin(pd_pin), .sw_pd_force(sw_pd_force),
    .pd_commit(pd_commit), .xtal_off(xtal_off), .ctx_clear_req(ctx_clear_req),
    .idle_cmd(idle_cmd), .idle_slow(idle_slow), .idle_div(idle_div), .irq_pend(irq_pend),
    .pd_irq(pd_irq), .pd_ack(pd_ack), .osc_en(osc_en), .core_en(core_en),
    .core_div_en(core_div_en), .dma_en(dma_en), .ctx_clear_sel(ctx_clear_sel));

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic reset_dut();
    @(negedge clk);
    rst_n = 0; pd_pin = 0; sw_pd_force = 0; pd_commit = 0; idle_cmd = 0; irq_pend = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic check_run_outputs(input string req);
    chk({req, " core_en"}, core_en, 1);
    chk({req, " core_div_en"}, core_div_en, 1);
    chk({req, " dma_en"}, dma_en, 1);
    chk({req, " osc_en"}, osc_en, 1);
    chk({req, " pd_ack"}, pd_ack, 0);
    chk({req, " pd_irq"}, pd_irq, 0);
    chk({req, " ctx_clear_sel"}, ctx_clear_sel, 1);
  endtask

  // Request (pin or software), check the interrupt, then commit.
  task automatic pd_enter(input bit use_sw, input bit xtal, input bit ctx);
    if (use_sw) sw_pd_force = 1; else pd_pin = 1;
    @(negedge clk);
    chk("R2 pd_irq raised", pd_irq, 1);
    chk("R2 core still runs", core_en, 1);
    @(negedge clk);
    chk("R2 pd_irq one cycle", pd_irq, 0);
    pd_commit = 1; xtal_off = xtal; ctx_clear_req = ctx;
    @(negedge clk);
    pd_commit = 0; sw_pd_force = 0;
    chk("R3 pd_ack", pd_ack, 1);
    chk("R3 core_en off", core_en, 0);
    chk("R3 core_div_en off", core_div_en, 0);
    chk("R3 dma_en off", dma_en, 0);
    chk("R4 osc_en", osc_en, xtal ? 0 : 1);
    chk("R7 ctx latched", ctx_clear_sel, ctx);
  endtask

  task automatic pd_exit(input string req, input int expect_cycles);
    int k = 0;
    bit osc_low = 0;
    pd_pin = 0;
    @(negedge clk);
    pd_pin = 1;
    forever begin
      @(negedge clk);
      if (core_en || k > XTAL + 50) break;
      if (!osc_en) osc_low = 1;
      k++;
    end
    pd_pin = 0;
    chk({req, " recovery cycles"}, k, expect_cycles);
    chk("R6 osc_en high in recovery", osc_low, 0);
    chk({req, " pd_ack cleared"}, pd_ack, 0);
  endtask

  task automatic t_reset();
    reset_dut();
    check_run_outputs("R1");
  endtask

  task automatic t_pd_fast();
    pd_enter(0, 0, 0);
    xtal_off = 1;
    sw_pd_force = 1;
    repeat (5) @(negedge clk);
    chk("R12 sw edge ignored in pd", pd_ack, 1);
    chk("R4 xtal_off change ignored", osc_en, 1);
    sw_pd_force = 0;
    pd_exit("R5", FAST);
    chk("R7 ctx held after exit", ctx_clear_sel, 0);
  endtask

  task automatic t_pd_xtal();
    pd_enter(1, 1, 1);
    repeat (3) @(negedge clk);
    chk("R4 osc stopped", osc_en, 0);
    pd_exit("R6", XTAL);
    chk("R6 osc_en after", osc_en, 1);
    chk("R7 ctx set", ctx_clear_sel, 1);
  endtask

  task automatic t_idle();
    idle_cmd = 1; idle_slow = 0;
    @(negedge clk);
    idle_cmd = 0;
    chk("R9 core_en idle", core_en, 0);
    chk("R9 core_div_en idle", core_div_en, 0);
    chk("R9 dma_en idle", dma_en, 1);
    repeat (10) @(negedge clk);
    chk("R9 still idle", core_en, 0);
    irq_pend = 1;
    @(negedge clk);
    irq_pend = 0;
    chk("R9 woken", core_en, 1);
  endtask

  task automatic t_slow(input logic [1:0] code);
    int n = 16 << code;
    int first = -1, second = -1;
    bit core_on = 0;
    idle_cmd = 1; idle_slow = 1; idle_div = code;
    @(negedge clk);
    idle_cmd = 0; idle_div = ~code;
    for (int k = 0; k < 3 * n; k++) begin
      if (core_en || !dma_en) core_on = 1;
      if (core_div_en) begin
        if (first < 0) first = k;
        else if (second < 0) second = k;
      end
      @(negedge clk);
    end
    chk("R10 first tick", first, n - 1);
    chk("R10 tick period", second - first, n);
    chk("R10 core_en off dma on", core_on, 0);
    irq_pend = 1;
    @(negedge clk);
    irq_pend = 0;
    chk("R10 wake", core_en, 1);
  endtask

  task automatic t_collision();
    pd_pin = 1; idle_cmd = 1; idle_slow = 0;
    @(negedge clk);
    idle_cmd = 0;
    chk("R11 pd wins pd_irq", pd_irq, 1);
    chk("R11 pd wins core_en", core_en, 1);
    repeat (3) @(negedge clk);
    chk("R11 not idle", core_en, 1);
    pd_commit = 1; xtal_off = 1; ctx_clear_req = 0;
    @(negedge clk);
    pd_commit = 0;
    chk("R8 in pd", pd_ack, 1);
    rst_n = 0;
    @(negedge clk);
    check_run_outputs("R8");
    rst_n = 1;
    @(negedge clk);
    pd_pin = 0;
    @(negedge clk);
  endtask

  task automatic t_pd_from_idle();
    idle_cmd = 1; idle_slow = 0;
    @(negedge clk);
    idle_cmd = 0;
    repeat (2) @(negedge clk);
    sw_pd_force = 1;
    @(negedge clk);
    chk("R11 idle left pd_irq", pd_irq, 1);
    chk("R11 idle left core_en", core_en, 1);
    sw_pd_force = 0;
    reset_dut();
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_pd_fast();
    t_pd_xtal();
    t_idle();
    for (int c = 0; c < 4; c++) t_slow(2'(c));
    t_collision();
    t_pd_from_idle();
    finish_run();
  end
endmodule